// File: doc/BRIEF.md
# Three-wire synthesiser programming interface

This block is the serial control front end of a frequency synthesiser with two loops. A host writes words on a serial clock and data pair. Other devices may share that pair. A select line that belongs only to this device frames each word. The three serial inputs are brought into the system clock domain, and bits are shifted in while the select line is high.

When the select line falls, the block looks at the bit count and at the last bit received, which is the address bit. If they match a legal format, the word's fields are copied into the register of the addressed loop. The first loop's register holds a divider ratio, a charge-pump code and a switch level. The second loop's register holds its own divider ratio, the reference divider select shared by both loops, a charge-pump code, a switch level and an optional test-mode extension.

Two switch port outputs, each with an output enable, drive the tuner's switching functions. In test mode these outputs carry internal loop test signals instead.

Top module: `synprog_if`

## Requirements
- R1: After a synchronous reset, all divider ratios, charge-pump codes, the reference select, test enable and test select are 0, and both switch port outputs and both output enables are 0 (high impedance).
- R2: Bits are taken MSB first on rising edges of `sclk_i` only while `sen_i` is high. Clock edges while `sen_i` is low change nothing.
- R3: A word whose last bit (bit 0) is 0 and whose length is exactly 19 bits loads loop 1: bits [18:4] give the divider, [3:2] the charge-pump code and [1] the switch level. Loop 2 state does not change.
- R4: A word whose bit 0 is 1 and whose length is 22 bits loads loop 2: [21:20] give the test select {T2,T1}, [19] the test enable T0, [18:7] the divider, [6:4] the reference select, [3:2] the charge-pump code and [1] the switch level. Loop 1 state does not change.
- R5: A word whose bit 0 is 1 and whose length is 20 bits (the T2/T1 bits left out) loads the loop 2 fields at the same positions as in R4. Test enable and test select are forced to 0, whatever bit 19 holds.
- R6: A word of any other length, or with an address bit that does not match its length, is discarded, and every register keeps its value.
- R7: The output enable of a switch port is set by the first valid word that addresses its loop. Only reset clears it.
- R8: Outside test mode, each switch port output shows the switch level last loaded for its loop.
- R9: In test mode the test select picks the port sources as (port 1, port 2): 0 gives both switch levels, 1 gives (reference test input, loop 1 feedback), 2 gives (reference, loop 2 feedback) and 3 gives (loop 1 feedback, loop 2 feedback). The test select reads 0 whenever test mode is off.
- R10: In test mode both output enables are driven high. When test mode ends, each enable returns to its R7 state.
- R11: The shift register and bit counter clear when `sen_i` rises, so a word left unfinished by an earlier frame does not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock, shared |
| sdata_i | input | 1 | Serial data, shared |
| sen_i | input | 1 | Device select that frames a word |
| tp_ref_i | input | 1 | Reference comparison test signal |
| tp_fb1_i | input | 1 | Loop 1 feedback divider test signal |
| tp_fb2_i | input | 1 | Loop 2 feedback divider test signal |
| div1_o | output | 15 | Loop 1 divider ratio |
| cp1_o | output | 2 | Loop 1 charge-pump code |
| div2_o | output | 12 | Loop 2 divider ratio |
| cp2_o | output | 2 | Loop 2 charge-pump code |
| ref_sel_o | output | 3 | Shared reference divider select |
| test_en_o | output | 1 | Test mode active |
| test_sel_o | output | 2 | Test function select {T2,T1} |
| sw1_o | output | 1 | Switch port 1 value |
| sw1_oe_o | output | 1 | Switch port 1 output enable |
| sw2_o | output | 1 | Switch port 2 value |
| sw2_oe_o | output | 1 | Switch port 2 output enable |

## Verification
Several properties are checked on every cycle. At most one loop loads per frame. Each divider holds its value unless its own load strobe fired. The bit counter holds still while the select line is low. The programmed-enable flags never fall. Test mode forces both enables on, the test select is 0 outside test mode, and a short loop 2 word clears test mode. Some behaviour only the directed scenarios can show: the exact field positions, which word lengths are accepted, the mapping of test selects to port sources, and the recovery after an unfinished frame.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
  localparam int DEF_DIV1_W = 15;
  localparam int DEF_DIV2_W = 12;
  localparam int DEF_REF_W  = 3;
  localparam int DEF_CP_W   = 2;
  localparam int DEF_SYNC_N = 2;

  // Port source selection used while test mode is active
  typedef enum logic [1:0] {
    TSEL_LEVELS  = 2'd0,
    TSEL_REF_FB1 = 2'd1,
    TSEL_REF_FB2 = 2'd2,
    TSEL_FB1_FB2 = 2'd3
  } tsel_e;
endpackage

// File: rtl/synprog_sync.sv
module synprog_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/synprog_shifter.sv
module synprog_shifter #(
  parameter int SR_W  = 22,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_lvl,
  input  logic             sdata_lvl,
  input  logic             sen_lvl,
  output logic [SR_W-1:0]  sr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_end_o
);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(SR_W + 1);

  logic sclk_prev_q;
  logic sen_prev_q;
  logic sclk_rise;
  logic sen_rise;

  assign sclk_rise = sclk_lvl & ~sclk_prev_q;
  assign sen_rise  = sen_lvl & ~sen_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      sen_prev_q  <= 1'b0;
      frame_end_o <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_lvl;
      sen_prev_q  <= sen_lvl;
      frame_end_o <= sen_prev_q & ~sen_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_o  <= '0;
      cnt_o <= '0;
    end else if (sen_rise) begin
      sr_o  <= '0;
      cnt_o <= '0;
    end else if (sen_lvl && sclk_rise) begin
      sr_o <= {sr_o[SR_W-2:0], sdata_lvl};
      if (cnt_o != CNT_CAP) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/synprog_decode.sv
module synprog_decode #(
  parameter int DIV1_W = 15,
  parameter int DIV2_W = 12,
  parameter int REF_W  = 3,
  parameter int CP_W   = 2,
  parameter int SR_W   = 22,
  parameter int CNT_W  = 5
) (
  input  logic [SR_W-1:0]   sr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              frame_end_i,
  output logic              load1_o,
  output logic              load2_o,
  output logic [DIV1_W-1:0] div1_o,
  output logic [DIV2_W-1:0] div2_o,
  output logic [REF_W-1:0]  ref_o,
  output logic [CP_W-1:0]   cp_o,
  output logic              lvl_o,
  output logic              test_en_o,
  output logic [1:0]        test_sel_o
);
  localparam int L1  = DIV1_W + CP_W + 2;
  localparam int L2S = DIV2_W + REF_W + CP_W + 3;
  localparam int L2F = L2S + 2;
  localparam int CP_LO  = 2;
  localparam int REF_LO = CP_LO + CP_W;
  localparam int DV2_LO = REF_LO + REF_W;

  logic addr;
  logic is_l1;
  logic is_l2s;
  logic is_l2f;

  assign addr   = sr_i[0];
  assign is_l1  = (cnt_i == CNT_W'(L1));
  assign is_l2s = (cnt_i == CNT_W'(L2S));
  assign is_l2f = (cnt_i == CNT_W'(L2F));

  assign load1_o = frame_end_i & ~addr & is_l1;
  assign load2_o = frame_end_i & addr & (is_l2s | is_l2f);

  assign lvl_o  = sr_i[1];
  assign cp_o   = sr_i[CP_LO +: CP_W];
  assign ref_o  = sr_i[REF_LO +: REF_W];
  assign div2_o = sr_i[DV2_LO +: DIV2_W];
  assign div1_o = sr_i[REF_LO +: DIV1_W];

  // Test bits count only in a full-length word
  assign test_en_o  = is_l2f & sr_i[L2S-1];
  assign test_sel_o = test_en_o ? sr_i[L2F-1:L2S] : 2'b00;
endmodule

// File: rtl/synprog_regs.sv
module synprog_regs
  import synprog_pkg::*;
#(
  parameter int DIV1_W = 15,
  parameter int DIV2_W = 12,
  parameter int REF_W  = 3,
  parameter int CP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load1_i,
  input  logic              load2_i,
  input  logic [DIV1_W-1:0] div1_i,
  input  logic [DIV2_W-1:0] div2_i,
  input  logic [REF_W-1:0]  ref_i,
  input  logic [CP_W-1:0]   cp_i,
  input  logic              lvl_i,
  input  logic              test_en_i,
  input  logic [1:0]        test_sel_i,
  input  logic              tp_ref_i,
  input  logic              tp_fb1_i,
  input  logic              tp_fb2_i,
  output logic [DIV1_W-1:0] div1_o,
  output logic [CP_W-1:0]   cp1_o,
  output logic [DIV2_W-1:0] div2_o,
  output logic [CP_W-1:0]   cp2_o,
  output logic [REF_W-1:0]  ref_o,
  output logic              test_en_o,
  output logic [1:0]        test_sel_o,
  output logic              oe1_prog_o,
  output logic              oe2_prog_o,
  output logic              sw1_o,
  output logic              sw1_oe_o,
  output logic              sw2_o,
  output logic              sw2_oe_o
);
  logic lvl1_q;
  logic lvl2_q;
  logic mux1;
  logic mux2;

  always_ff @(posedge clk) begin
    if (rst) begin
      div1_o     <= '0;
      cp1_o      <= '0;
      lvl1_q     <= 1'b0;
      oe1_prog_o <= 1'b0;
    end else if (load1_i) begin
      div1_o     <= div1_i;
      cp1_o      <= cp_i;
      lvl1_q     <= lvl_i;
      oe1_prog_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div2_o     <= '0;
      cp2_o      <= '0;
      ref_o      <= '0;
      lvl2_q     <= 1'b0;
      test_en_o  <= 1'b0;
      test_sel_o <= 2'b00;
      oe2_prog_o <= 1'b0;
    end else if (load2_i) begin
      div2_o     <= div2_i;
      cp2_o      <= cp_i;
      ref_o      <= ref_i;
      lvl2_q     <= lvl_i;
      test_en_o  <= test_en_i;
      test_sel_o <= test_sel_i;
      oe2_prog_o <= 1'b1;
    end
  end

  always_comb begin
    case (tsel_e'(test_sel_o))
      TSEL_REF_FB1: begin mux1 = tp_ref_i; mux2 = tp_fb1_i; end
      TSEL_REF_FB2: begin mux1 = tp_ref_i; mux2 = tp_fb2_i; end
      TSEL_FB1_FB2: begin mux1 = tp_fb1_i; mux2 = tp_fb2_i; end
      default:      begin mux1 = lvl1_q;   mux2 = lvl2_q;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw1_o    <= 1'b0;
      sw2_o    <= 1'b0;
      sw1_oe_o <= 1'b0;
      sw2_oe_o <= 1'b0;
    end else begin
      sw1_o    <= test_en_o ? mux1 : lvl1_q;
      sw2_o    <= test_en_o ? mux2 : lvl2_q;
      sw1_oe_o <= test_en_o | oe1_prog_o;
      sw2_oe_o <= test_en_o | oe2_prog_o;
    end
  end
endmodule

// File: rtl/synprog_if.sv
module synprog_if
  import synprog_pkg::*;
#(
  parameter int DIV1_W = DEF_DIV1_W,
  parameter int DIV2_W = DEF_DIV2_W,
  parameter int REF_W  = DEF_REF_W,
  parameter int CP_W   = DEF_CP_W,
  parameter int SYNC_N = DEF_SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sen_i,
  input  logic              tp_ref_i,
  input  logic              tp_fb1_i,
  input  logic              tp_fb2_i,
  output logic [DIV1_W-1:0] div1_o,
  output logic [CP_W-1:0]   cp1_o,
  output logic [DIV2_W-1:0] div2_o,
  output logic [CP_W-1:0]   cp2_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              test_en_o,
  output logic [1:0]        test_sel_o,
  output logic              sw1_o,
  output logic              sw1_oe_o,
  output logic              sw2_o,
  output logic              sw2_oe_o
);
  localparam int L1    = DIV1_W + CP_W + 2;
  localparam int L2F   = DIV2_W + REF_W + CP_W + 5;
  localparam int SR_W  = (L1 > L2F) ? L1 : L2F;
  localparam int CNT_W = $clog2(SR_W + 2);

  logic [2:0]        ser_lvl;
  logic              sclk_lvl;
  logic              sdata_lvl;
  logic              sen_lvl;
  logic [SR_W-1:0]   sr;
  logic [CNT_W-1:0]  sr_cnt;
  logic              frame_end;
  logic              load1;
  logic              load2;
  logic [DIV1_W-1:0] dec_div1;
  logic [DIV2_W-1:0] dec_div2;
  logic [REF_W-1:0]  dec_ref;
  logic [CP_W-1:0]   dec_cp;
  logic              dec_lvl;
  logic              dec_ten;
  logic [1:0]        dec_tsel;
  logic              oe1_prog;
  logic              oe2_prog;

  synprog_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_i   ({sen_i, sdata_i, sclk_i}),
    .lvl_o (ser_lvl)
  );

  assign sclk_lvl  = ser_lvl[0];
  assign sdata_lvl = ser_lvl[1];
  assign sen_lvl   = ser_lvl[2];

  synprog_shifter #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .sclk_lvl    (sclk_lvl),
    .sdata_lvl   (sdata_lvl),
    .sen_lvl     (sen_lvl),
    .sr_o        (sr),
    .cnt_o       (sr_cnt),
    .frame_end_o (frame_end)
  );

  synprog_decode #(
    .DIV1_W(DIV1_W), .DIV2_W(DIV2_W), .REF_W(REF_W), .CP_W(CP_W),
    .SR_W(SR_W), .CNT_W(CNT_W)
  ) u_dec (
    .sr_i        (sr),
    .cnt_i       (sr_cnt),
    .frame_end_i (frame_end),
    .load1_o     (load1),
    .load2_o     (load2),
    .div1_o      (dec_div1),
    .div2_o      (dec_div2),
    .ref_o       (dec_ref),
    .cp_o        (dec_cp),
    .lvl_o       (dec_lvl),
    .test_en_o   (dec_ten),
    .test_sel_o  (dec_tsel)
  );

  synprog_regs #(
    .DIV1_W(DIV1_W), .DIV2_W(DIV2_W), .REF_W(REF_W), .CP_W(CP_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .load1_i    (load1),
    .load2_i    (load2),
    .div1_i     (dec_div1),
    .div2_i     (dec_div2),
    .ref_i      (dec_ref),
    .cp_i       (dec_cp),
    .lvl_i      (dec_lvl),
    .test_en_i  (dec_ten),
    .test_sel_i (dec_tsel),
    .tp_ref_i   (tp_ref_i),
    .tp_fb1_i   (tp_fb1_i),
    .tp_fb2_i   (tp_fb2_i),
    .div1_o     (div1_o),
    .cp1_o      (cp1_o),
    .div2_o     (div2_o),
    .cp2_o      (cp2_o),
    .ref_o      (ref_sel_o),
    .test_en_o  (test_en_o),
    .test_sel_o (test_sel_o),
    .oe1_prog_o (oe1_prog),
    .oe2_prog_o (oe2_prog),
    .sw1_o      (sw1_o),
    .sw1_oe_o   (sw1_oe_o),
    .sw2_o      (sw2_o),
    .sw2_oe_o   (sw2_oe_o)
  );
endmodule

// File: rtl/synprog_if_chk.sv
module synprog_if_chk #(
  parameter int DIV1_W = 15,
  parameter int DIV2_W = 12,
  parameter int REF_W  = 3,
  parameter int CP_W   = 2,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sen_lvl,
  input logic [CNT_W-1:0]  sr_cnt,
  input logic              load1,
  input logic              load2,
  input logic              oe1_prog,
  input logic              oe2_prog,
  input logic [DIV1_W-1:0] div1_o,
  input logic [DIV2_W-1:0] div2_o,
  input logic              test_en_o,
  input logic [1:0]        test_sel_o,
  input logic              sw1_oe_o,
  input logic              sw2_oe_o
);
  localparam int L2S = DIV2_W + REF_W + CP_W + 3;

  assert_one_load_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load1, load2}));

  assert_div1_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(load1) |-> $stable(div1_o));

  assert_div2_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(load2) |-> $stable(div2_o));

  assert_gated_count_R2: assert property (@(posedge clk) disable iff (rst)
    !sen_lvl |=> $stable(sr_cnt));

  assert_oe1_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !$fell(oe1_prog));

  assert_oe2_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !$fell(oe2_prog));

  assert_test_forces_oe_R10: assert property (@(posedge clk) disable iff (rst)
    test_en_o |=> (sw1_oe_o && sw2_oe_o));

  assert_sel_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !test_en_o |-> (test_sel_o == 2'b00));

  assert_short_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (load2 && (sr_cnt == CNT_W'(L2S))) |=> !test_en_o);
endmodule

bind synprog_if synprog_if_chk #(
  .DIV1_W(DIV1_W), .DIV2_W(DIV2_W), .REF_W(REF_W), .CP_W(CP_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sen_lvl    (sen_lvl),
  .sr_cnt     (sr_cnt),
  .load1      (load1),
  .load2      (load2),
  .oe1_prog   (oe1_prog),
  .oe2_prog   (oe2_prog),
  .div1_o     (div1_o),
  .div2_o     (div2_o),
  .test_en_o  (test_en_o),
  .test_sel_o (test_sel_o),
  .sw1_oe_o   (sw1_oe_o),
  .sw2_oe_o   (sw2_oe_o)
);

// File: tb/synprog_if_tb.sv
module synprog_if_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, sen = 1'b0;
  logic tp_ref = 1'b0, tp_fb1 = 1'b0, tp_fb2 = 1'b0;
  logic [14:0] div1;
  logic [1:0]  cp1, cp2, tsel;
  logic [11:0] div2;
  logic [2:0]  refs;
  logic        ten, sw1, sw1_oe, sw2, sw2_oe;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  synprog_if u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .sen_i(sen),
    .tp_ref_i(tp_ref), .tp_fb1_i(tp_fb1), .tp_fb2_i(tp_fb2),
    .div1_o(div1), .cp1_o(cp1), .div2_o(div2), .cp2_o(cp2),
    .ref_sel_o(refs), .test_en_o(ten), .test_sel_o(tsel),
    .sw1_o(sw1), .sw1_oe_o(sw1_oe), .sw2_o(sw2), .sw2_oe_o(sw2_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sends the low n bits of w, MSB first
  task automatic send(input logic [31:0] w, input int n);
    sen = 1'b1;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      wait_clk(2);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(2);
    end
    wait_clk(4);
    sen = 1'b0;
    wait_clk(12);
  endtask

  function automatic logic [31:0] w1(input logic [14:0] d, input logic [1:0] c, input logic l);
    return {13'd0, d, c, l, 1'b0};
  endfunction

  function automatic logic [31:0] w2(input logic [1:0] ts, input logic t0, input logic [11:0] d,
                                     input logic [2:0] r, input logic [1:0] c, input logic l);
    return {10'd0, ts, t0, d, r, c, l, 1'b1};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "div1", div1, 0);
    chk("R1", "div2", div2, 0);
    chk("R1", "cp1/cp2/ref", {cp1, cp2, refs}, 0);
    chk("R1", "test en/sel", {ten, tsel}, 0);
    chk("R1", "ports", {sw1, sw1_oe, sw2, sw2_oe}, 0);
  endtask

  task automatic t_loop1();
    send(w1(15'h2A5C, 2'b10, 1'b1), 19);
    chk("R3", "div1", div1, 32'h2A5C);
    chk("R3", "cp1", cp1, 2);
    chk("R3", "div2 untouched", div2, 0);
    chk("R7", "oe1 set, oe2 off", {sw1_oe, sw2_oe}, 2'b10);
    chk("R8", "sw1 level", sw1, 1);
  endtask

  task automatic t_loop2_full();
    send(w2(2'b00, 1'b0, 12'hA5B, 3'b101, 2'b01, 1'b0), 22);
    chk("R4", "div2", div2, 32'hA5B);
    chk("R4", "ref", refs, 5);
    chk("R4", "cp2", cp2, 1);
    chk("R4", "test off", {ten, tsel}, 0);
    chk("R4", "div1 untouched", div1, 32'h2A5C);
    chk("R7", "oe2 set", sw2_oe, 1);
    chk("R8", "sw2 level", sw2, 0);
  endtask

  task automatic t_bad_len();
    send(w1(15'h7FFF, 2'b11, 1'b0), 18);
    send(w2(2'b11, 1'b1, 12'hFFF, 3'b111, 2'b11, 1'b1), 21);
    send(w1(15'h1111, 2'b01, 1'b0) | 32'h1, 19);
    send(w2(2'b01, 1'b0, 12'h333, 3'b011, 2'b10, 1'b1) & 32'hFFFF_FFFE, 20);
    send(32'h7F_FFFF, 23);
    chk("R6", "div1 kept", div1, 32'h2A5C);
    chk("R6", "div2 kept", div2, 32'hA5B);
    chk("R6", "cp1/cp2/ref kept", {cp1, cp2, refs}, {2'b10, 2'b01, 3'b101});
    chk("R6", "test kept off", ten, 0);
  endtask

  task automatic t_test_mode();
    tp_ref = 1'b1; tp_fb1 = 1'b0; tp_fb2 = 1'b1;
    send(w2(2'b01, 1'b1, 12'h123, 3'b011, 2'b10, 1'b0), 22);
    chk("R4", "test en/sel", {ten, tsel}, 3'b101);
    chk("R9", "sel1 ports", {sw1, sw2}, 2'b10);
    chk("R10", "oe forced", {sw1_oe, sw2_oe}, 2'b11);
    send(w2(2'b11, 1'b1, 12'h123, 3'b011, 2'b10, 1'b0), 22);
    chk("R9", "sel3 ports", {sw1, sw2}, 2'b01);
    send(w2(2'b10, 1'b1, 12'h123, 3'b011, 2'b10, 1'b0), 22);
    chk("R9", "sel2 ports", {sw1, sw2}, 2'b11);
  endtask

  task automatic t_short();
    send(w2(2'b00, 1'b1, 12'h0F0, 3'b010, 2'b11, 1'b1), 20);
    chk("R5", "test cleared", {ten, tsel}, 0);
    chk("R5", "div2", div2, 32'h0F0);
    chk("R5", "ref/cp2", {refs, cp2}, {3'b010, 2'b11});
    chk("R8", "levels back", {sw1, sw2}, 2'b11);
  endtask

  task automatic t_gating();
    sdata = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    wait_clk(8);
    chk("R2", "div1 with enable low", div1, 32'h2A5C);
    send(32'h3FF, 10);
    send(w1(15'h0123, 2'b01, 1'b0), 19);
    chk("R11", "div1 after aborted frame", div1, 32'h0123);
    chk("R11", "cp1/sw1", {cp1, sw1}, 3'b010);
  endtask

  task automatic t_port_oe();
    do_reset();
    send(w2(2'b00, 1'b1, 12'h055, 3'b001, 2'b01, 1'b1), 22);
    chk("R10", "oe1 forced in test", sw1_oe, 1);
    chk("R9", "sel0 levels", {sw1, sw2}, 2'b01);
    send(w2(2'b00, 1'b0, 12'h055, 3'b001, 2'b01, 1'b1), 20);
    chk("R7", "oe1 back off, oe2 on", {sw1_oe, sw2_oe}, 2'b01);
    chk("R1", "div1 still reset", div1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_loop1();
    t_loop2_full();
    t_bad_len();
    t_test_mode();
    t_short();
    t_gating();
    t_port_oe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule